// File: doc/BRIEF.md
# Protected system clock control unit

This block holds the byte-wide control register that governs the system clock, together with the source selection and main-clock division logic that the register drives. Software writes the register through a plain write strobe and data byte and reads it back combinationally. Every write is filtered: a global unlock input must be high for any field to change. Two lock inputs then shield the stop and source-select fields, and hardware rules reject unsafe stop requests and force the oscillator drive level high when the clock is about to stop.

The datapath side turns two source strobes (a main-oscillator tick and a PLL tick) into a single system clock enable. The main tick passes through a divider with ratios 1, 2, 4 or 16, or through undivided when a bypass input is high. The select field chooses the PLL only while two external mode inputs are both low and only after the PLL has reported ready. Divider changes are applied on a divided-clock boundary, so no shortened enable period is ever produced. A set stop field holds the enable low and is reported as the stop request.

Top module: `sysclk_ctrl`

## Requirements
- R1: A write (wr_en=1) changes no register field unless wr_unlock=1; rdata is unchanged after a write made with wr_unlock=0.
- R2: While clk_lock=1, a write leaves the stop field (bit 0) and the select field (bit 1) unchanged, while the divider code (bits 7:6) and drive field (bit 5) are still written.
- R3: While stop_lock=1, a write leaves the stop field unchanged; the other fields are written normally.
- R4: With bypass low, main source in use and no stop, sys_en is high on one of every N main ticks, N = 1, 2, 4, 16 for divider code 00, 01, 10, 11.
- R5: With div_bypass=1 the divider code is not applied and every main tick gives a sys_en pulse.
- R6: With the select field at 1 and alt_mode_a=alt_mode_b=0, src_pll=1 and sys_en follows pll_tick; if either mode input is 1, src_pll=0 and the main path is used.
- R7: drive_hi is set to 1 by hardware, overriding the written value, when the stop field goes from 0 to 1 with speed_mode 00 (high) or 01 (middle), and one cycle after main_osc_off=1 is seen with speed_mode 10 (low); stop entry with speed_mode 10 leaves the written drive value.
- R8: A write setting the stop field is rejected while the select field is 1 or osc_mon_en=1.
- R9: The register resets to 0x20 (bit 0 stop=0, bit 1 select=0, bit 5 drive=1, bits 7:6 divider=00), and rdata shows the register with that layout.
- R10: Bits 4:2 read as 0 whatever value was written to them.
- R11: A write of select=1 while pll_ready=0 leaves the select field at 0 and is held; the field becomes 1 in the cycle after pll_ready=1 is seen.
- R12: A divider code change takes effect only at the next divided-clock boundary; the period in progress completes at the old ratio.
- R13: While the stop field is 1, stop_req=1 and sys_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data |
| wr_unlock | input | 1 | Global write permission; writes are ignored while 0 |
| clk_lock | input | 1 | Freezes the stop and select fields |
| stop_lock | input | 1 | Freezes the stop field |
| div_bypass | input | 1 | Main path undivided; divider code not applied |
| alt_mode_a | input | 1 | External mode that blocks the PLL select |
| alt_mode_b | input | 1 | Second external mode that blocks the PLL select |
| pll_ready | input | 1 | PLL reports stable output |
| osc_mon_en | input | 1 | Oscillation-stop monitor enabled; stop writes rejected |
| speed_mode | input | 2 | 00 high, 01 middle, 10 low, 11 low-power |
| main_osc_off | input | 1 | Main oscillator turned off |
| main_tick | input | 1 | Main-oscillator enable strobe |
| pll_tick | input | 1 | PLL enable strobe |
| sys_en | output | 1 | Selected, divided system clock enable |
| src_pll | output | 1 | PLL source is in use |
| stop_req | output | 1 | Stop-mode request |
| drive_hi | output | 1 | Oscillator drive strength high |

## Verification
The stop-entry write and the hardware drive-level rule fall in the same cycle: one write both sets the stop field and clears the drive field. The bench provokes this in high-speed mode, where the forced level must win and rdata must read 0x21, and again in low-speed mode, where the written 0 must survive and rdata must read 0x01. A second collision, a divider write landing on the very edge that closes a divided period, is provoked by issuing the write right after a pulse and judged by measuring that the next gap is still the old 16 cycles.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

  localparam int MAX_DIV  = 16;
  localparam int REG_W    = 8;
  localparam logic [REG_W-1:0] RST_VAL = 8'h20;

  typedef enum logic [1:0] {
    SPD_HIGH = 2'b00,
    SPD_MID  = 2'b01,
    SPD_LOW  = 2'b10,
    SPD_LP   = 2'b11
  } spd_e;

  typedef struct packed {
    logic [1:0] div;
    logic       drive;
    logic       sel;
    logic       stop;
  } ctl_t;

  // terminal count (ratio minus one) for a divider code
  function automatic int div_limit(input logic [1:0] code);
    case (code)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 3;
      default: return MAX_DIV - 1;
    endcase
  endfunction

endpackage

// File: rtl/sysclk_regs.sv
module sysclk_regs
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             wr_unlock,
  input  logic             clk_lock,
  input  logic             stop_lock,
  input  logic             osc_mon_en,
  input  logic             pll_ready,
  input  logic [1:0]       speed_mode,
  input  logic             main_osc_off,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rdata
);

  ctl_t ctl_q, ctl_n;
  logic pend_q, pend_n;
  logic wr_ok;
  logic stop_entry;
  logic fast_mode;
  logic slow_off;

  assign wr_ok     = wr_en & wr_unlock;
  assign fast_mode = (speed_mode == SPD_HIGH) || (speed_mode == SPD_MID);
  assign slow_off  = main_osc_off && (speed_mode == SPD_LOW);

  always_comb begin
    ctl_n  = ctl_q;
    pend_n = pend_q;
    if (pend_q && pll_ready) begin
      ctl_n.sel = 1'b1;
      pend_n    = 1'b0;
    end
    if (wr_ok) begin
      ctl_n.div   = wdata[7:6];
      ctl_n.drive = wdata[5];
      if (!clk_lock) begin
        if (!wdata[1]) begin
          ctl_n.sel = 1'b0;
          pend_n    = 1'b0;
        end else if (pll_ready) begin
          ctl_n.sel = 1'b1;
          pend_n    = 1'b0;
        end else if (!ctl_q.sel) begin
          pend_n    = 1'b1;
        end
        if (!stop_lock) begin
          if (!wdata[0]) begin
            ctl_n.stop = 1'b0;
          end else if (!ctl_q.sel && !osc_mon_en) begin
            ctl_n.stop = 1'b1;
          end
        end
      end
    end
    stop_entry = ctl_n.stop & ~ctl_q.stop;
    if ((stop_entry && fast_mode) || slow_off) begin
      ctl_n.drive = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '{div: 2'b00, drive: 1'b1, sel: 1'b0, stop: 1'b0};
      pend_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_n;
      pend_q <= pend_n;
    end
  end

  assign ctl   = ctl_q;
  assign rdata = {ctl_q.div, ctl_q.drive, 3'b000, ctl_q.sel, ctl_q.stop};

  // R1: nothing moves without an accepted write or a hardware event
  a_r1_hold_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_unlock) && !pend_q && !slow_off) |=> $stable(rdata));

  // R2: clock lock freezes stop and select (no pending select open)
  a_r2_lock_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lock && !pend_q) |=> ($stable(rdata[0]) && $stable(rdata[1])));

  // R3: stop lock freezes the stop field
  a_r3_stop_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    stop_lock |=> $stable(rdata[0]));

  // R8: no stop entry while PLL selected or monitor enabled
  a_r8_stop_reject: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata[1] || osc_mon_en) && !rdata[0]) |=> !rdata[0]);

  // R7: stop entry from a fast mode leaves drive high
  a_r7_drive_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rdata[0]) && ($past(speed_mode) == SPD_HIGH || $past(speed_mode) == SPD_MID))
      |-> rdata[5]);

  // R7: main oscillator off in low speed forces drive high
  a_r7_drive_on_off: assert property (@(posedge clk) disable iff (!rst_n)
    slow_off |=> rdata[5]);

  // R11: select only rises once the PLL reported ready
  a_r11_pll_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[1]) |-> $past(pll_ready));

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
  import sysclk_pkg::*;
#(
  parameter int CNT_W = $clog2(MAX_DIV)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] code,
  input  logic       bypass,
  output logic       pulse
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] lim_q, lim_n;
  logic             cnt_en;
  logic             boundary;

  assign boundary = tick && (cnt_q == lim_q);
  assign cnt_en   = tick;
  assign pulse    = boundary;

  always_comb begin
    cnt_n = boundary ? '0 : cnt_q + 1'b1;
    lim_n = bypass ? '0 : CNT_W'(div_limit(code));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      if (cnt_en)   cnt_q <= cnt_n;
      if (boundary) lim_q <= lim_n;
    end
  end

  // R12: the active ratio only changes on a divided-clock boundary
  a_r12_ratio_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(lim_q));

  // R4: the counter never runs past the active terminal count
  a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);

endmodule

// File: rtl/sysclk_mux.sv
module sysclk_mux (
  input  logic sel,
  input  logic alt_mode_a,
  input  logic alt_mode_b,
  input  logic stop,
  input  logic main_pulse,
  input  logic pll_tick,
  output logic use_pll,
  output logic sys_en
);

  logic src_pulse;

  assign use_pll   = sel & ~alt_mode_a & ~alt_mode_b;
  assign src_pulse = use_pll ? pll_tick : main_pulse;
  assign sys_en    = src_pulse & ~stop;

endmodule

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl
  import sysclk_pkg::*;
#(
  parameter int DIV_CNT_W = $clog2(MAX_DIV),
  parameter int SYNC_LEN  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       wr_unlock,
  input  logic       clk_lock,
  input  logic       stop_lock,
  input  logic       div_bypass,
  input  logic       alt_mode_a,
  input  logic       alt_mode_b,
  input  logic       pll_ready,
  input  logic       osc_mon_en,
  input  logic [1:0] speed_mode,
  input  logic       main_osc_off,
  input  logic       main_tick,
  input  logic       pll_tick,
  output logic       sys_en,
  output logic       src_pll,
  output logic       stop_req,
  output logic       drive_hi
);

  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_int_n;
  ctl_t                ctl;
  logic                main_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_LEN-1];

  sysclk_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_en        (wr_en),
    .wdata        (wdata),
    .wr_unlock    (wr_unlock),
    .clk_lock     (clk_lock),
    .stop_lock    (stop_lock),
    .osc_mon_en   (osc_mon_en),
    .pll_ready    (pll_ready),
    .speed_mode   (speed_mode),
    .main_osc_off (main_osc_off),
    .ctl          (ctl),
    .rdata        (rdata)
  );

  sysclk_div #(.CNT_W(DIV_CNT_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .tick   (main_tick),
    .code   (ctl.div),
    .bypass (div_bypass),
    .pulse  (main_pulse)
  );

  sysclk_mux u_mux (
    .sel        (ctl.sel),
    .alt_mode_a (alt_mode_a),
    .alt_mode_b (alt_mode_b),
    .stop       (ctl.stop),
    .main_pulse (main_pulse),
    .pll_tick   (pll_tick),
    .use_pll    (src_pll),
    .sys_en     (sys_en)
  );

  assign stop_req = ctl.stop;
  assign drive_hi = ctl.drive;

  // R13: a stopped clock emits no enable
  a_r13_stop_gates: assert property (@(posedge clk) disable iff (!rst_int_n)
    stop_req |-> !sys_en);

endmodule

// File: tb/tb_sysclk_ctrl.sv
`timescale 1ns/1ps
module tb_sysclk_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_unlock, clk_lock, stop_lock, div_bypass;
  logic       alt_mode_a, alt_mode_b, pll_ready, osc_mon_en, main_osc_off;
  logic       main_tick, pll_tick;
  logic [1:0] speed_mode;
  logic [7:0] wdata, rdata;
  logic       sys_en, src_pll, stop_req, drive_hi;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sysclk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .wr_unlock(wr_unlock), .clk_lock(clk_lock), .stop_lock(stop_lock),
    .div_bypass(div_bypass), .alt_mode_a(alt_mode_a), .alt_mode_b(alt_mode_b),
    .pll_ready(pll_ready), .osc_mon_en(osc_mon_en), .speed_mode(speed_mode),
    .main_osc_off(main_osc_off), .main_tick(main_tick), .pll_tick(pll_tick),
    .sys_en(sys_en), .src_pll(src_pll), .stop_req(stop_req), .drive_hi(drive_hi)
  );

  // {code[1:0], bypass, expected pulses in 64 ticks}
  localparam logic [9:0] VEC [6] = '{
    {2'b00, 1'b0, 7'd64},
    {2'b01, 1'b0, 7'd32},
    {2'b10, 1'b0, 7'd16},
    {2'b11, 1'b0, 7'd4},
    {2'b11, 1'b1, 7'd64},
    {2'b10, 1'b1, 7'd64}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] v);
    wdata = v;
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic count64(output int n);
    n = 0;
    for (int k = 0; k < 64; k++) begin
      step();
      if (sys_en) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int gap;
    rst_n = 1'b0; wr_en = 1'b0; wdata = 8'h00; wr_unlock = 1'b0;
    clk_lock = 1'b0; stop_lock = 1'b0; div_bypass = 1'b0;
    alt_mode_a = 1'b0; alt_mode_b = 1'b0; pll_ready = 1'b0;
    osc_mon_en = 1'b0; main_osc_off = 1'b0; speed_mode = 2'b00;
    main_tick = 1'b0; pll_tick = 1'b0;
    repeat (3) step();
    chk("R9 reset rdata", rdata, 8'h20);
    chk("R9 reset drive_hi", drive_hi, 1);
    chk("R13 reset stop_req", stop_req, 0);
    rst_n = 1'b1;
    repeat (3) step();

    // R1: write without unlock
    wr(8'hC3);
    chk("R1 locked write ignored", rdata, 8'h20);
    wr_unlock = 1'b1;

    // R10: reserved bits read zero
    wr(8'hFC);
    chk("R10 reserved bits zero", rdata, 8'hE0);

    // R4, R5: divider table
    main_tick = 1'b1;
    for (int i = 0; i < 6; i++) begin
      logic [9:0] v;
      v = VEC[i];
      div_bypass = v[7];
      wr({v[9:8], 6'b000000});
      repeat (20) step();
      count64(n);
      if (v[7]) chk("R5 bypass pulse count", n, int'(v[6:0]));
      else      chk("R4 divider pulse count", n, int'(v[6:0]));
    end
    div_bypass = 1'b0;

    // R12: change ratio just after a pulse; current period keeps old ratio
    wr(8'hC0);
    repeat (20) step();
    n = 0;
    while (!sys_en && n < 40) begin step(); n++; end
    wdata = 8'h00;
    wr_en = 1'b1;
    gap = 0;
    do begin
      step();
      wr_en = 1'b0;
      gap++;
    end while (!sys_en && gap < 40);
    chk("R12 old period completes", gap, 16);
    step();
    chk("R12 new ratio applied", sys_en, 1);

    // R2: clock lock
    clk_lock = 1'b1;
    wr(8'h43);
    chk("R2 lock keeps stop/sel, writes div", rdata, 8'h40);
    clk_lock = 1'b0;
    wr(8'h00);

    // R3: stop lock
    stop_lock = 1'b1;
    wr(8'h81);
    chk("R3 stop lock", rdata, 8'h80);
    stop_lock = 1'b0;
    wr(8'h00);

    // R11: select held until PLL ready
    wr(8'h02);
    chk("R11 select held", rdata, 8'h00);
    step();
    chk("R11 still held", rdata, 8'h00);
    pll_ready = 1'b1;
    step();
    chk("R11 select after ready", rdata, 8'h02);

    // R6: source mux
    main_tick = 1'b0;
    pll_tick = 1'b1;
    step();
    chk("R6 pll in use", src_pll, 1);
    chk("R6 pll tick passes", sys_en, 1);
    alt_mode_b = 1'b1;
    step();
    chk("R6 mode blocks pll", src_pll, 0);
    chk("R6 main path used", sys_en, 0);
    alt_mode_b = 1'b0;
    pll_tick = 1'b0;
    main_tick = 1'b1;

    // R8: stop rejected while PLL selected, then with monitor on
    wr(8'h03);
    chk("R8 stop rejected on pll", rdata, 8'h02);
    wr(8'h00);
    osc_mon_en = 1'b1;
    wr(8'h01);
    chk("R8 stop rejected on monitor", rdata, 8'h00);
    osc_mon_en = 1'b0;

    // R7 with R13: stop entry in high speed while writing drive 0
    speed_mode = 2'b00;
    wr(8'h01);
    chk("R7 drive forced on stop", rdata, 8'h21);
    chk("R13 stop_req", stop_req, 1);
    chk("R13 sys_en gated", sys_en, 0);
    wr(8'h00);
    chk("R13 stop cleared", stop_req, 0);

    // R7: low speed stop keeps written drive; main off forces it
    speed_mode = 2'b10;
    wr(8'h01);
    chk("R7 low speed no force", rdata, 8'h01);
    main_osc_off = 1'b1;
    step();
    chk("R7 main off forces drive", rdata, 8'h21);
    main_osc_off = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule